// File: doc/BRIEF.md
# Pipelined Constant-Coefficient Lookup Multiplier

This block multiplies a stream of unsigned words by one coefficient that is fixed when the design is elaborated. It accepts one operand on every clock. The operand is cut into four equal slices. Each slice selects an entry from its own small table, and each table holds every possible slice value multiplied by the coefficient. The tables are filled at elaboration time from the coefficient parameter.

The four table outputs pass through a two-level registered adder tree. The first level joins slices 0 and 1, and in parallel joins slices 2 and 3. The higher slice of each pair is shifted up by one slice width. The second level adds the upper pair, shifted up by two slice widths, to the lower pair. The result is the exact full-width product.

A valid flag travels with the data through the same three register stages. A synchronous reset empties only this valid pipeline. The data registers load only when their stage holds a valid operand, so the product output keeps its last result between valid outputs.

Top module: `const_lut_mult`

## Requirements
- R1: Whenever `outValid` is high, `product` equals the operand presented three clocks earlier multiplied by `COEF`. The product is exact and unsigned, `IN_W+K_W` bits wide, and does not overflow. This includes an all-ones operand with an all-ones coefficient.
- R2: `outValid` is high in exactly the cycles that follow, by three rising clock edges, a cycle in which `inValid` was sampled high with reset low.
- R3: Operands marked valid on consecutive clocks each produce their own correct product, on consecutive clocks, with no stall.
- R4: A clock with `inValid` low produces a clock with `outValid` low three cycles later. It does not alter the products of the valid operands before or after it.
- R5: While `rst` is sampled high, the valid pipeline is cleared. `outValid` stays low during reset and for the three clocks after it, whatever `inValid` does during that time.
- R6: While `outValid` is low, `product` keeps the value it had on the last cycle that `outValid` was high. This also holds across a reset.
- R7: With `COEF` set to zero, every valid output has `product` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Marks `opIn` as an operand to multiply |
| opIn | input | IN_W | Unsigned operand |
| outValid | output | 1 | Marks `product` as a fresh result |
| product | output | IN_W+K_W | Unsigned product of the operand and `COEF` |

## Verification
Directed operands come first: zero, one, all ones and a lone top bit. Together they separate a wrongly weighted slice or a dropped carry from a correct sum, and the all-ones case exposes truncation. An unbroken burst and an alternating valid pattern then show whether stages leak into one another. A long stream with about seventy percent random occupancy mixes both conditions. A reset applied with operands in flight shows that stale valids are discarded and that the held product does not move. A second instance with a zero coefficient runs alongside and must report zero for every valid output.

// File: rtl/const_lut_mult_pkg.sv
package const_lut_mult_pkg;
  localparam int unsigned NUM_SLICES = 4;
  localparam int unsigned PIPE_DEPTH = 3;

  typedef struct packed {
    logic ldTab;
    logic ldSum1;
    logic ldSum2;
  } stageStrobes_t;
endpackage

// File: rtl/const_lut_mult_ctrl.sv
module const_lut_mult_ctrl
  import const_lut_mult_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stageStrobes_t str,
  output logic          outValid
);
  logic [PIPE_DEPTH-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[PIPE_DEPTH-2:0], inValid};
  end

  always_comb begin
    str.ldTab  = inValid  & ~rst;
    str.ldSum1 = vPipe[0] & ~rst;
    str.ldSum2 = vPipe[1] & ~rst;
  end

  assign outValid = vPipe[PIPE_DEPTH-1];

  // R2: a valid result always traces back to an accepted operand
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3));

  // R5: the last stage never reloads while reset is applied
  assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);
endmodule

// File: rtl/const_lut_mult_dp.sv
module const_lut_mult_dp
  import const_lut_mult_pkg::*;
#(
  parameter int unsigned IN_W = 16,
  parameter int unsigned K_W  = 16,
  parameter logic [K_W-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stageStrobes_t        str,
  input  logic [IN_W-1:0]      opIn,
  output logic [IN_W+K_W-1:0]  product
);
  localparam int unsigned SW     = IN_W / NUM_SLICES;
  localparam int unsigned DEPTH  = 2 ** SW;
  localparam int unsigned TAB_W  = K_W + SW;
  localparam int unsigned PAIR_W = K_W + 2 * SW;
  localparam int unsigned OUT_W  = IN_W + K_W;

  logic [TAB_W-1:0] tabQ [NUM_SLICES];

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [TAB_W-1:0] rom [DEPTH];
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      assign rom[e] = TAB_W'(e) * TAB_W'(COEF);
    end
    always_ff @(posedge clk) begin
      if (str.ldTab) tabQ[s] <= rom[opIn[s*SW +: SW]];
    end
  end

  logic [PAIR_W-1:0] sumLo, sumHi;

  always_ff @(posedge clk) begin
    if (str.ldSum1) begin
      sumLo <= PAIR_W'(tabQ[0]) + (PAIR_W'(tabQ[1]) << SW);
      sumHi <= PAIR_W'(tabQ[2]) + (PAIR_W'(tabQ[3]) << SW);
    end
  end

  always_ff @(posedge clk) begin
    if (str.ldSum2) product <= OUT_W'(sumLo) + (OUT_W'(sumHi) << (2 * SW));
  end

  // R6: the output register only moves when the control grants a load
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !str.ldSum2 |=> $stable(product));
endmodule

// File: rtl/const_lut_mult.sv
module const_lut_mult
  import const_lut_mult_pkg::*;
#(
  parameter int unsigned IN_W = 16,
  parameter int unsigned K_W  = 16,
  parameter logic [K_W-1:0] COEF = 16'hB5A3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [IN_W-1:0]     opIn,
  output logic                outValid,
  output logic [IN_W+K_W-1:0] product
);
  localparam int unsigned OUT_W = IN_W + K_W;

  stageStrobes_t str;

  const_lut_mult_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .str(str), .outValid(outValid)
  );

  const_lut_mult_dp #(.IN_W(IN_W), .K_W(K_W), .COEF(COEF)) dp_i (
    .clk(clk), .rst(rst), .str(str), .opIn(opIn), .product(product)
  );

  // R1: end-to-end exact product three clocks after the operand
  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> product == OUT_W'($past(opIn, 3)) * OUT_W'(COEF));
endmodule

// File: tb/const_lut_mult_tb_top.sv
`timescale 1ns/1ps
module const_lut_mult_tb_top;
  localparam int unsigned IN_W = 16;
  localparam int unsigned K_W  = 16;
  localparam logic [K_W-1:0] COEF = 16'hB5A3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [IN_W-1:0] opIn = '0;
  logic outValid, zValid;
  logic [IN_W+K_W-1:0] product, zProduct;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic hv [3];
  logic [IN_W-1:0] hd [3];
  logic [31:0] lastProd;
  bit haveLast = 0;
  string tag = "R5";

  always #2.5 clk = ~clk;

  const_lut_mult #(.IN_W(IN_W), .K_W(K_W), .COEF(COEF)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opIn(opIn),
    .outValid(outValid), .product(product));

  const_lut_mult #(.IN_W(IN_W), .K_W(K_W), .COEF(16'h0000)) dutZero_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opIn(opIn),
    .outValid(zValid), .product(zProduct));

  function automatic logic [31:0] refMul(input logic [15:0] a, input logic [15:0] k);
    return {16'h0, a} * {16'h0, k};
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [IN_W-1:0] d, input logic r);
    @(negedge clk);
    checkEq({"R2 valid/", tag}, {31'h0, outValid}, {31'h0, hv[2]});
    checkEq({"R7 zero-coef valid/", tag}, {31'h0, zValid}, {31'h0, hv[2]});
    if (hv[2]) begin
      lastProd = refMul(hd[2], COEF);
      haveLast = 1;
      checkEq({"R1 product/", tag}, product, lastProd);
      checkEq("R7 zero product", zProduct, 32'h0);
    end else if (haveLast) begin
      checkEq({"R6 hold/", tag}, product, lastProd);
    end
    if (r) begin
      for (int i = 0; i < 3; i++) hv[i] = 1'b0;
    end else begin
      hv[2] = hv[1]; hd[2] = hd[1];
      hv[1] = hv[0]; hd[1] = hd[0];
      hv[0] = v;     hd[0] = d;
    end
    rst = r; inValid = v; opIn = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hd[i] = '0; end

    tag = "R5";
    for (int i = 0; i < 4; i++) step(1'b1, 16'(i * 7 + 1), 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0);

    tag = "R1 corner";
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 1'b0);
    step(1'b1, 16'h0001, 1'b0);
    step(1'b1, 16'h8000, 1'b0);
    step(1'b1, 16'h000F, 1'b0);
    step(1'b1, 16'hF000, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 16'hDEAD, 1'b0);

    tag = "R3 burst";
    for (int i = 0; i < 24; i++) step(1'b1, 16'($urandom), 1'b0);

    tag = "R4 bubble";
    for (int i = 0; i < 24; i++) step(i[0], 16'($urandom), 1'b0);

    tag = "R4 random";
    for (int i = 0; i < 2000; i++) step(($urandom % 10) < 7, 16'($urandom), 1'b0);

    tag = "R5 midrun";
    for (int i = 0; i < 3; i++) step(1'b1, 16'($urandom), 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 16'($urandom), 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 16'($urandom), 1'b0);

    tag = "R3 tail";
    for (int i = 0; i < 200; i++) step(($urandom % 4) != 0, 16'($urandom), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule